// File: doc/BRIEF.md
# Page Translation Cache with Identity Windows

This block turns a 32-bit logical address into a physical address within the same cycle. It holds a small fully associative store of recently used page translations, and it has two identity windows that pass whole 16 MB regions through unchanged. Each lookup reports four things: whether a translation was found, the physical address, a two-bit cache mode and a protection fault flag. A chip uses one instance for data accesses and a second, equally sized instance for instruction fetches.

The block does not walk page tables. When a lookup misses, an external walker fetches the descriptor and writes it back through the fill port. Two invalidate commands keep the store coherent. One clears every entry. The other clears only the entries that are not marked global, for use on a context switch. A plain register write port loads the control register and the two window registers.

Top module: `xlat_cache`

## Requirements
- R1: After reset, translation is off and every entry is invalid. While translation is off, every lookup reports a hit, returns the logical address unchanged, and gives cache mode 00 and no fault.
- R2: A write with `cfg_sel`=0 loads the control register: bit 15 turns translation on and bit 14 selects the page size (0 = 4 KB, 1 = 8 KB). In 8 KB mode, logical address bit 12 is left out of the tag compare and is copied straight into the physical address.
- R3: When translation is on, a lookup that matches a valid entry reports a hit in the same cycle. The physical address is the stored frame followed by the untranslated offset, and the cache mode is the one stored in the entry. A lookup that matches nothing reports hit=0, address 0, mode 00 and no fault.
- R4: A hit on a write-protected entry faults when `lk_write`=1. A hit on a supervisor-only entry faults when `lk_super`=0. Otherwise no fault is reported.
- R5: Window registers are written with `cfg_sel`=1 (window 0) and `cfg_sel`=2 (window 1). Register bits 31:24 hold the base and bits 23:16 the mask. The window matches when bit 15 is set and logical address bits 31:24 equal the base in every position whose mask bit is clear.
- R6: When translation is on, a matching window takes priority over the store, and window 0 takes priority over window 1. The window returns the logical address unchanged, uses its own cache mode from register bits 6:5, and reports no fault.
- R7: A fill takes effect at the next clock edge. A fill for a page that is already held overwrites that entry and creates no second copy.
- R8: A fill for a new page goes to the first invalid entry found at or after a round-robin pointer, wrapping around. If no entry is invalid, it goes to the entry at the pointer. The pointer then moves to the slot after the one written.
- R9: `flush_all` invalidates every entry at the next clock edge.
- R10: `flush_nonglobal` invalidates only the entries whose global flag is clear.
- R11: A fill that arrives in the same cycle as either flush command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 window 0, 2 window 1, 3 none |
| cfg_wdata | input | 32 | Register write data |
| lk_addr | input | 32 | Logical address to translate |
| lk_write | input | 1 | The access is a write |
| lk_super | input | 1 | The access is made in supervisor mode |
| lk_hit | output | 1 | A translation was found |
| lk_paddr | output | 32 | Physical address |
| lk_cmode | output | 2 | Cache mode: 00 write-through, 01 copyback, 10 uncached serialized, 11 uncached |
| lk_fault | output | 1 | Protection violation on a hit |
| fill_en | input | 1 | Fill strobe from the walker |
| fill_vpn | input | 20 | Logical page number (address bits 31:12) |
| fill_ppn | input | 20 | Physical frame number (address bits 31:12) |
| fill_wprot | input | 1 | Entry is write-protected |
| fill_sup | input | 1 | Entry is supervisor-only |
| fill_global | input | 1 | Entry survives a non-global flush |
| fill_cmode | input | 2 | Entry cache mode |
| flush_all | input | 1 | Invalidate all entries |
| flush_nonglobal | input | 1 | Invalidate the entries that are not global |

## Verification
The hardest case to reach is replacement once the store is full, together with the preference for invalid slots. Both depend on a pointer that cannot be seen from the ports. The bench makes the pointer's position known by filling all 64 slots after a flush, which brings the pointer back to where it started. It then opens a single hole with a non-global flush and fills twice. The first fill must land in the hole. The second must evict the page that was filled just after the hole.

// File: rtl/xc_pkg.sv
// Shared types for the page translation cache.
// Assumes 32-bit logical and physical addresses and pages of at least 4 KB.
package xc_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned OFF_MIN = 12;
    localparam int unsigned PN_W    = ADDR_W - OFF_MIN;

    typedef enum logic [1:0] {
        CM_WTHRU  = 2'b00,
        CM_CPBACK = 2'b01,
        CM_NC_SER = 2'b10,
        CM_NC     = 2'b11
    } cmode_e;

    typedef struct packed {
        logic [PN_W-1:0] tag;
        logic [PN_W-1:0] frame;
        logic            wprot;
        logic            sup_only;
        logic            glob;
        cmode_e          cm;
    } xc_entry_t;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] mask;
        logic       en;
        cmode_e     cm;
    } xc_win_t;
endpackage

// File: rtl/xc_window.sv
// Identity window compare: decides whether one window covers the address.
// Assumes the register fields have already been unpacked into xc_win_t.
module xc_window
    import xc_pkg::*;
(
    input  xc_win_t    win,
    input  logic [7:0] addr_hi,
    output logic       match,
    output cmode_e     cm
);
    // Compare only the address bits whose mask bit is clear.
    always_comb begin
        match = win.en && (((addr_hi ^ win.base) & ~win.mask) == 8'h00);
        cm    = win.cm;
    end
endmodule

// File: rtl/xc_victim.sv
// Victim selection: returns the first invalid slot at or after the pointer,
// wrapping around, or the pointer itself when every slot is valid.
// Assumes N is a power of two, so the index wraps naturally.
module xc_victim #(
    parameter int unsigned N = 64,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [IW-1:0] rr,
    output logic [IW-1:0] victim,
    output logic          any_free
);
    // Scan offsets from the highest down so the smallest offset wins.
    always_comb begin
        victim   = rr;
        any_free = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            logic [IW-1:0] idx;
            idx = rr + IW'(k);
            if (!valid[idx]) begin
                victim   = idx;
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xc_array.sv
// Fully associative entry store with one lookup port, one fill port and the
// two invalidate commands. Entry payloads are not reset; only the valid bits are.
// Assumes at most one valid entry matches a tag under the current page size.
module xc_array
    import xc_pkg::*;
#(
    parameter int unsigned N = 64,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            page8k,
    input  logic [PN_W-1:0] lk_tag,
    output logic            lk_hit,
    output xc_entry_t       lk_ent,
    input  logic            fill_en,
    input  xc_entry_t       fill_ent,
    input  logic            flush_all,
    input  logic            flush_ng
);
    xc_entry_t       ents [N];
    logic [N-1:0]    valid;
    logic [N-1:0]    glob_vec;
    logic [IW-1:0]   rr;
    logic [IW-1:0]   hit_idx;
    logic [IW-1:0]   fhit_idx;
    logic            fill_hit;
    logic [IW-1:0]   victim;
    logic            any_free;
    logic [IW-1:0]   sel;
    logic            do_fill;
    logic [PN_W-1:0] tmask;

    // In 8 KB mode bit 0 of the page number is not part of the tag.
    assign tmask   = page8k ? {{(PN_W-1){1'b1}}, 1'b0} : {PN_W{1'b1}};
    assign do_fill = fill_en && !flush_all && !flush_ng;

    // Gather the global flags for the selective flush.
    always_comb begin
        for (int i = 0; i < N; i++) glob_vec[i] = ents[i].glob;
    end

    // Lookup and fill-address match, lowest index first.
    always_comb begin
        lk_hit   = 1'b0;
        hit_idx  = '0;
        fill_hit = 1'b0;
        fhit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid[i] && (((ents[i].tag ^ lk_tag) & tmask) == '0)) begin
                lk_hit  = 1'b1;
                hit_idx = IW'(i);
            end
            if (valid[i] && (((ents[i].tag ^ fill_ent.tag) & tmask) == '0)) begin
                fill_hit = 1'b1;
                fhit_idx = IW'(i);
            end
        end
    end

    assign lk_ent = ents[hit_idx];

    xc_victim #(.N(N)) u_victim (
        .valid    (valid),
        .rr       (rr),
        .victim   (victim),
        .any_free (any_free)
    );

    // A fill for a page already held rewrites that entry.
    assign sel = fill_hit ? fhit_idx : victim;

    // Valid bits and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            rr    <= '0;
        end else if (flush_all) begin
            valid <= '0;
        end else if (flush_ng) begin
            valid <= valid & glob_vec;
        end else if (fill_en) begin
            valid[sel] <= 1'b1;
            if (!fill_hit) rr <= sel + 1'b1;
        end
    end

    // Entry payload storage.
    always_ff @(posedge clk) begin
        if (do_fill) ents[sel] <= fill_ent;
    end

    // R9
    flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid == '0));

    // R10
    flush_ng_keeps_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ng && !flush_all) |=> ((valid & ~glob_vec) == '0));

    // R7
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_fill |=> valid[$past(sel)]);

    // R8
    victim_free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_fill && !fill_hit && any_free) |-> !valid[victim]);
endmodule

// File: rtl/xlat_cache.sv
// Page translation cache top: control and window registers, window
// priority, lookup result assembly and protection check.
// Assumes the walker fills only after a miss and that software flushes
// after changing the page size.
module xlat_cache
    import xc_pkg::*;
#(
    parameter int unsigned ENTRIES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] lk_addr,
    input  logic        lk_write,
    input  logic        lk_super,
    output logic        lk_hit,
    output logic [31:0] lk_paddr,
    output logic [1:0]  lk_cmode,
    output logic        lk_fault,
    input  logic        fill_en,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_ppn,
    input  logic        fill_wprot,
    input  logic        fill_sup,
    input  logic        fill_global,
    input  logic [1:0]  fill_cmode,
    input  logic        flush_all,
    input  logic        flush_nonglobal
);
    localparam int unsigned NWIN = 2;

    logic      tr_en;
    logic      page8k;
    xc_win_t   win     [NWIN];
    logic      wmatch  [NWIN];
    cmode_e    wcm     [NWIN];
    xc_win_t   wnew;
    logic      arr_hit;
    xc_entry_t arr_ent;
    xc_entry_t fent;
    logic      unused_cfg;

    assign unused_cfg = ^{cfg_wdata[13:7], cfg_wdata[4:0]};
    assign wnew = '{base: cfg_wdata[31:24], mask: cfg_wdata[23:16],
                    en: cfg_wdata[15], cm: cmode_e'(cfg_wdata[6:5])};

    // Control and window register write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_en  <= 1'b0;
            page8k <= 1'b0;
            for (int w = 0; w < NWIN; w++) win[w] <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == 2'd0) begin
                tr_en  <= cfg_wdata[15];
                page8k <= cfg_wdata[14];
            end
            for (int w = 0; w < NWIN; w++)
                if (cfg_sel == 2'(w + 1)) win[w] <= wnew;
        end
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        xc_window u_win (
            .win     (win[g]),
            .addr_hi (lk_addr[31:24]),
            .match   (wmatch[g]),
            .cm      (wcm[g])
        );
    end

    assign fent = '{tag: fill_vpn, frame: fill_ppn, wprot: fill_wprot,
                    sup_only: fill_sup, glob: fill_global,
                    cm: cmode_e'(fill_cmode)};

    xc_array #(.N(ENTRIES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .page8k   (page8k),
        .lk_tag   (lk_addr[31:12]),
        .lk_hit   (arr_hit),
        .lk_ent   (arr_ent),
        .fill_en  (fill_en),
        .fill_ent (fent),
        .flush_all(flush_all),
        .flush_ng (flush_nonglobal)
    );

    // Result selection: off, window 0, window 1, store, miss.
    always_comb begin
        lk_hit   = 1'b0;
        lk_paddr = '0;
        lk_cmode = CM_WTHRU;
        lk_fault = 1'b0;
        if (!tr_en) begin
            lk_hit   = 1'b1;
            lk_paddr = lk_addr;
        end else if (wmatch[0]) begin
            lk_hit   = 1'b1;
            lk_paddr = lk_addr;
            lk_cmode = wcm[0];
        end else if (wmatch[1]) begin
            lk_hit   = 1'b1;
            lk_paddr = lk_addr;
            lk_cmode = wcm[1];
        end else if (arr_hit) begin
            lk_hit   = 1'b1;
            lk_paddr = {arr_ent.frame[19:1],
                        page8k ? lk_addr[12] : arr_ent.frame[0],
                        lk_addr[11:0]};
            lk_cmode = arr_ent.cm;
            lk_fault = (lk_write && arr_ent.wprot) || (!lk_super && arr_ent.sup_only);
        end
    end

    // R4
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_hit && tr_en));

    // R1
    off_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tr_en |-> (lk_hit && lk_paddr == lk_addr && !lk_fault));
endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] lk_addr = '0;
    logic        lk_write = 1'b0;
    logic        lk_super = 1'b1;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic [1:0]  lk_cmode;
    logic        lk_fault;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_wprot = 1'b0;
    logic        fill_sup = 1'b0;
    logic        fill_global = 1'b0;
    logic [1:0]  fill_cmode = '0;
    logic        flush_all = 1'b0;
    logic        flush_nonglobal = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    xlat_cache dut (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                           input logic wp, input logic so, input logic g,
                           input logic [1:0] cm);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        fill_wprot = wp; fill_sup = so; fill_global = g; fill_cmode = cm;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic pulse_flush(input logic all, input logic ng);
        @(negedge clk);
        flush_all = all; flush_nonglobal = ng;
        @(negedge clk);
        flush_all = 1'b0; flush_nonglobal = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input logic w, input logic s);
        @(negedge clk);
        lk_addr = a; lk_write = w; lk_super = s;
        #1;
    endtask

    task automatic t_reset();
        look(32'hDEADBEEF, 1'b1, 1'b0);
        chk("R1 hit", 32'(lk_hit), 32'd1);
        chk("R1 paddr", lk_paddr, 32'hDEADBEEF);
        chk("R1 cmode", 32'(lk_cmode), 32'd0);
        chk("R1 fault", 32'(lk_fault), 32'd0);
    endtask

    task automatic t_basic();
        wr_reg(2'd0, 32'h0000_8000);
        look(32'h0040_1234, 1'b0, 1'b1);
        chk("R3 miss hit", 32'(lk_hit), 32'd0);
        chk("R3 miss paddr", lk_paddr, 32'd0);
        do_fill(20'h00401, 20'h7A0B3, 1'b0, 1'b0, 1'b0, 2'b01);
        look(32'h0040_1ABC, 1'b0, 1'b1);
        chk("R7 fill hit", 32'(lk_hit), 32'd1);
        chk("R3 paddr", lk_paddr, 32'h7A0B_3ABC);
        chk("R3 cmode", 32'(lk_cmode), 32'd1);
    endtask

    task automatic t_fault();
        do_fill(20'h00500, 20'h11111, 1'b1, 1'b1, 1'b0, 2'b00);
        look(32'h0050_0010, 1'b1, 1'b1);
        chk("R4 write on protected", 32'(lk_fault), 32'd1);
        look(32'h0050_0010, 1'b0, 1'b1);
        chk("R4 supervisor read", 32'(lk_fault), 32'd0);
        look(32'h0050_0010, 1'b0, 1'b0);
        chk("R4 user on supervisor-only", 32'(lk_fault), 32'd1);
        do_fill(20'h00600, 20'h22222, 1'b0, 1'b0, 1'b0, 2'b00);
        look(32'h0060_0010, 1'b1, 1'b0);
        chk("R4 open page", 32'(lk_fault), 32'd0);
    endtask

    task automatic t_page8k();
        wr_reg(2'd0, 32'h0000_C000);
        do_fill(20'h00802, 20'h33334, 1'b0, 1'b0, 1'b0, 2'b10);
        look(32'h0080_3456, 1'b0, 1'b1);
        chk("R2 8k hit", 32'(lk_hit), 32'd1);
        chk("R2 8k paddr", lk_paddr, 32'h3333_5456);
        wr_reg(2'd0, 32'h0000_8000);
        look(32'h0080_3456, 1'b0, 1'b1);
        chk("R2 4k miss", 32'(lk_hit), 32'd0);
    endtask

    task automatic t_window();
        do_fill(20'h12345, 20'hABCDE, 1'b1, 1'b0, 1'b0, 2'b01);
        look(32'h1234_5678, 1'b1, 1'b1);
        chk("R3 before window", lk_paddr, 32'hABCD_E678);
        wr_reg(2'd1, 32'h1200_8040);
        look(32'h1234_5678, 1'b1, 1'b1);
        chk("R6 w0 paddr", lk_paddr, 32'h1234_5678);
        chk("R6 w0 cmode", 32'(lk_cmode), 32'd2);
        chk("R6 w0 no fault", 32'(lk_fault), 32'd0);
        wr_reg(2'd2, 32'h100F_8060);
        look(32'h1A00_0000, 1'b0, 1'b1);
        chk("R5 masked match", 32'(lk_hit), 32'd1);
        chk("R5 w1 cmode", 32'(lk_cmode), 32'd3);
        look(32'h1234_5678, 1'b0, 1'b1);
        chk("R6 w0 over w1", 32'(lk_cmode), 32'd2);
        look(32'h2A00_0000, 1'b0, 1'b1);
        chk("R5 outside window", 32'(lk_hit), 32'd0);
        wr_reg(2'd1, 32'h1200_0040);
        look(32'h1234_5678, 1'b0, 1'b1);
        chk("R5 disabled w0", 32'(lk_cmode), 32'd3);
        wr_reg(2'd2, 32'h0000_0000);
        look(32'h1234_5678, 1'b0, 1'b1);
        chk("R6 back to store", lk_paddr, 32'hABCD_E678);
    endtask

    task automatic t_flush();
        do_fill(20'h00A00, 20'h0AAAA, 1'b0, 1'b0, 1'b1, 2'b00);
        do_fill(20'h00B00, 20'h0BBBB, 1'b0, 1'b0, 1'b0, 2'b00);
        pulse_flush(1'b0, 1'b1);
        look(32'h00A0_0000, 1'b0, 1'b1);
        chk("R10 global kept", 32'(lk_hit), 32'd1);
        look(32'h00B0_0000, 1'b0, 1'b1);
        chk("R10 non-global gone", 32'(lk_hit), 32'd0);
        pulse_flush(1'b1, 1'b0);
        look(32'h00A0_0000, 1'b0, 1'b1);
        chk("R9 global gone", 32'(lk_hit), 32'd0);
        look(32'h1234_5678, 1'b0, 1'b1);
        chk("R9 other gone", 32'(lk_hit), 32'd0);
    endtask

    task automatic t_overwrite();
        do_fill(20'h00C00, 20'h01000, 1'b0, 1'b0, 1'b0, 2'b00);
        do_fill(20'h00C00, 20'h02000, 1'b0, 1'b0, 1'b0, 2'b11);
        look(32'h00C0_0123, 1'b0, 1'b1);
        chk("R7 overwrite paddr", lk_paddr, 32'h0200_0123);
        chk("R7 overwrite cmode", 32'(lk_cmode), 32'd3);
    endtask

    task automatic t_flush_fill();
        @(negedge clk);
        flush_all = 1'b1;
        fill_en = 1'b1; fill_vpn = 20'h00D00; fill_ppn = 20'h0DDDD;
        fill_wprot = 1'b0; fill_sup = 1'b0; fill_global = 1'b1; fill_cmode = 2'b00;
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
        look(32'h00D0_0000, 1'b0, 1'b1);
        chk("R11 fill dropped", 32'(lk_hit), 32'd0);
    endtask

    task automatic t_replace();
        int misses;
        pulse_flush(1'b1, 1'b0);
        for (int i = 0; i < 64; i++)
            do_fill(20'h00100 + 20'(i), 20'h00800 + 20'(i), 1'b0, 1'b0, (i != 5), 2'b00);
        misses = 0;
        for (int i = 0; i < 64; i++) begin
            look((32'h100 + 32'(i)) << 12, 1'b0, 1'b1);
            if (!lk_hit) misses++;
        end
        chk("R8 full store misses", 32'(misses), 32'd0);
        pulse_flush(1'b0, 1'b1);
        do_fill(20'h00300, 20'h00900, 1'b0, 1'b0, 1'b1, 2'b00);
        misses = 0;
        for (int i = 0; i < 64; i++) begin
            if (i != 5) begin
                look((32'h100 + 32'(i)) << 12, 1'b0, 1'b1);
                if (!lk_hit) misses++;
            end
        end
        look(32'h0030_0000, 1'b0, 1'b1);
        if (!lk_hit) misses++;
        chk("R8 hole used first", 32'(misses), 32'd0);
        do_fill(20'h00301, 20'h00901, 1'b0, 1'b0, 1'b1, 2'b00);
        look(32'h0010_6000, 1'b0, 1'b1);
        chk("R8 evict at pointer", 32'(lk_hit), 32'd0);
        look(32'h0010_7000, 1'b0, 1'b1);
        chk("R8 next kept", 32'(lk_hit), 32'd1);
        look(32'h0010_4000, 1'b0, 1'b1);
        chk("R8 earlier kept", 32'(lk_hit), 32'd1);
        look(32'h0030_1000, 1'b0, 1'b1);
        chk("R8 new page", lk_paddr, 32'h0090_1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_fault();
        t_page8k();
        t_window();
        t_flush();
        t_overwrite();
        t_flush_fill();
        t_replace();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule